// File: doc/BRIEF.md
# Product-Term Cluster Steering Allocator

This block routes one-bit cluster values, each a precomputed sum of products, to the OR gates of nearby macrocells. Static configuration bits select the target. Each cluster carries a 2-bit steering code that picks one macrocell from a small neighbourhood around the cluster's own index. Each macrocell output is the OR of every cluster steered to it. The block has no clock and no stored state.

Each macrocell draws from a sliding window of clusters. For macrocell n the window is clusters n-1 to n+2, and it is cut short at both ends of the array. A code that would send a cluster past either end of the array drops that cluster and raises that cluster's error bit. A summary error output also goes high. The array size is a parameter: 16 by default, with a 12-entry variant that follows the same rules.

Top module: `ptc_steer_alloc`

## Requirements
- R1: Cluster i's steering code is `steer_cfg[2i+1:2i]`. Code 0 sends the cluster to macrocell i+1, code 1 to macrocell i, code 2 to i-1 and code 3 to i-2.
- R2: A cluster with a valid code reaches exactly one macrocell. `mc_sum[m]` is the OR of all clusters steered to macrocell m.
- R3: A macrocell that no cluster is steered to, or that receives only zero-valued clusters, outputs 0.
- R4: When a code points below index 0 or above index NCELL-1, that cluster's value reaches no macrocell and `steer_err[i]` is 1. `cfg_err` is the OR of all `steer_err` bits.
- R5: The window is clipped at the edges. Macrocell 0 can receive only clusters 0, 1 and 2. Macrocell NCELL-2 can receive only clusters NCELL-3 to NCELL-1. Macrocell NCELL-1 can receive only clusters NCELL-2 and NCELL-1.
- R6: Clusters 2 to NCELL-2 never raise an error, whatever their code.
- R7: With NCELL=12, the same mapping, window and error rules hold at the smaller array's edges.
- R8: The outputs depend only on the present inputs. They follow any input change with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cluster_in | input | NCELL | One precomputed sum-of-products value per cluster |
| steer_cfg | input | 2*NCELL | Steering code per cluster, two bits each |
| mc_sum | output | NCELL | OR of the clusters steered to each macrocell |
| steer_err | output | NCELL | Per-cluster flag: code points outside the array |
| cfg_err | output | 1 | Any cluster flagged |

## Verification
The assertions assume the inputs have settled to known 0/1 values whenever they are evaluated. The window and dropped-cluster checks also assume that cluster values and codes change in the same step. The bench meets both assumptions: it drives every bit of both input buses at once, at the falling edge of its clock, and never drives X or Z. Single-hot cluster patterns isolate one cluster's route. Random vectors then cover arbitrary mixes of values and codes, including every error-producing code at both edges.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
    localparam int CODE_W = 2;

    typedef enum logic [CODE_W-1:0] {
        STEER_UP   = 2'd0,
        STEER_SELF = 2'd1,
        STEER_DN1  = 2'd2,
        STEER_DN2  = 2'd3
    } steer_e;
endpackage

// File: rtl/ptc_steer_decode.sv
module ptc_steer_decode
    import ptc_pkg::*;
#(
    parameter int NCELL = 16,
    parameter int IDX   = 0
) (
    input  logic [CODE_W-1:0] code,
    output logic [NCELL-1:0]  route,
    output logic              err
);
    localparam int  T_UP   = IDX + 1;
    localparam int  T_SELF = IDX;
    localparam int  T_DN1  = IDX - 1;
    localparam int  T_DN2  = IDX - 2;
    localparam bit  OK_UP  = (T_UP < NCELL);
    localparam bit  OK_DN1 = (T_DN1 >= 0);
    localparam bit  OK_DN2 = (T_DN2 >= 0);
    localparam int  S_UP   = OK_UP  ? T_UP  : 0;
    localparam int  S_DN1  = OK_DN1 ? T_DN1 : 0;
    localparam int  S_DN2  = OK_DN2 ? T_DN2 : 0;

    always_comb begin
        route = '0;
        err   = 1'b0;
        unique case (steer_e'(code))
            STEER_UP: begin
                if (OK_UP) route[S_UP] = 1'b1;
                else       err         = 1'b1;
            end
            STEER_SELF: begin
                route[T_SELF] = 1'b1;
            end
            STEER_DN1: begin
                if (OK_DN1) route[S_DN1] = 1'b1;
                else        err          = 1'b1;
            end
            STEER_DN2: begin
                if (OK_DN2) route[S_DN2] = 1'b1;
                else        err          = 1'b1;
            end
            default: begin
                route = '0;
                err   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/ptc_sum_merge.sv
module ptc_sum_merge #(
    parameter int NCELL = 16
) (
    input  logic [NCELL*NCELL-1:0] route_flat,
    input  logic [NCELL-1:0]       cluster_in,
    output logic [NCELL-1:0]       mc_sum
);
    always_comb begin
        mc_sum = '0;
        for (int m = 0; m < NCELL; m++) begin
            for (int c = 0; c < NCELL; c++) begin
                mc_sum[m] = mc_sum[m] | (route_flat[c*NCELL + m] & cluster_in[c]);
            end
        end
    end
endmodule

// File: rtl/ptc_steer_alloc.sv
module ptc_steer_alloc
    import ptc_pkg::*;
#(
    parameter int NCELL = 16
) (
    input  logic [NCELL-1:0]        cluster_in,
    input  logic [CODE_W*NCELL-1:0] steer_cfg,
    output logic [NCELL-1:0]        mc_sum,
    output logic [NCELL-1:0]        steer_err,
    output logic                    cfg_err
);
    localparam int ROUTE_W = NCELL * NCELL;

    logic [ROUTE_W-1:0] route_flat;

    for (genvar i = 0; i < NCELL; i++) begin : g_cluster
        ptc_steer_decode #(
            .NCELL (NCELL),
            .IDX   (i)
        ) u_dec (
            .code  (steer_cfg[CODE_W*i +: CODE_W]),
            .route (route_flat[NCELL*i +: NCELL]),
            .err   (steer_err[i])
        );
    end

    ptc_sum_merge #(
        .NCELL (NCELL)
    ) u_merge (
        .route_flat (route_flat),
        .cluster_in (cluster_in),
        .mc_sum     (mc_sum)
    );

    assign cfg_err = |steer_err;
endmodule

// File: rtl/ptc_steer_alloc_chk.sv
module ptc_steer_alloc_chk
    import ptc_pkg::*;
#(
    parameter int NCELL = 16
) (
    input logic [NCELL-1:0]        cluster_in,
    input logic [CODE_W*NCELL-1:0] steer_cfg,
    input logic [NCELL-1:0]        mc_sum,
    input logic [NCELL-1:0]        steer_err,
    input logic                    cfg_err
);
    logic unused_in;
    assign unused_in = ^steer_cfg;

    always_comb begin
        // R3: nothing set at the inputs means nothing at the outputs
        if (cluster_in == '0) begin
            a_r3_idle_zero: assert (mc_sum == '0)
                else $error("R3 macrocell active with no cluster set");
        end
        // R2: a macrocell count never exceeds the cluster count
        a_r2_no_fanout: assert ($countones(mc_sum) <= $countones(cluster_in))
            else $error("R2 cluster reached several macrocells");
        // R4: summary flag agrees with presence of any per-cluster flag
        a_r4_flag_seen: assert (cfg_err == (steer_err != '0))
            else $error("R4 summary error flag mismatch");
        for (int m = 0; m < NCELL; m++) begin
            logic win;
            win = 1'b0;
            for (int j = 0; j < NCELL; j++) begin
                if (j >= m - 1 && j <= m + 2) win = win | cluster_in[j];
            end
            // R5: an active macrocell has an active cluster in its window
            a_r5_window: assert (!mc_sum[m] || win)
                else $error("R5 macrocell %0d fed from outside its window", m);
        end
        for (int i = 0; i < NCELL; i++) begin
            if (cluster_in == (NCELL'(1) << i) && steer_err[i]) begin
                a_r4_err_drop: assert (mc_sum == '0)
                    else $error("R4 flagged cluster %0d still reached a macrocell", i);
            end
            if (i >= 2 && i <= NCELL - 2) begin
                a_r6_interior_ok: assert (!steer_err[i])
                    else $error("R6 interior cluster %0d flagged", i);
            end
        end
    end
endmodule

bind ptc_steer_alloc ptc_steer_alloc_chk #(.NCELL(NCELL)) u_chk (.*);

// File: tb/tb_ptc_steer_alloc.sv
`timescale 1ns/1ps
module tb_ptc_steer_alloc;
    localparam int NA = 16;
    localparam int NB = 12;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [NA-1:0]   a_cl;
    logic [2*NA-1:0] a_cfg;
    logic [NA-1:0]   a_sum, a_err;
    logic            a_any;
    logic [NB-1:0]   b_cl;
    logic [2*NB-1:0] b_cfg;
    logic [NB-1:0]   b_sum, b_err;
    logic            b_any;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    ptc_steer_alloc #(.NCELL(NA)) dut (
        .cluster_in(a_cl), .steer_cfg(a_cfg),
        .mc_sum(a_sum), .steer_err(a_err), .cfg_err(a_any));

    ptc_steer_alloc #(.NCELL(NB)) dut12 (
        .cluster_in(b_cl), .steer_cfg(b_cfg),
        .mc_sum(b_sum), .steer_err(b_err), .cfg_err(b_any));

    // Expected outputs from the stated code mapping (R1, R2, R4)
    task automatic model(input int n, input logic [15:0] c, input logic [31:0] cfg,
                         output logic [15:0] s, output logic [15:0] e);
        s = '0;
        e = '0;
        for (int i = 0; i < n; i++) begin
            int t;
            t = i + 1 - int'(cfg[2*i +: 2]);
            if (t >= 0 && t < n) s[t] = s[t] | c[i];
            else                 e[i] = 1'b1;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply_a(input string req, input logic [15:0] c, input logic [31:0] cfg);
        logic [15:0] s, e;
        @(negedge clk);
        a_cl  = c;
        a_cfg = cfg;
        #1;
        model(NA, c, cfg, s, e);
        check({req, " sum"}, 32'(a_sum), 32'(s));
        check({req, " err"}, {15'd0, a_any, a_err}, {15'd0, (e != 0), e});
    endtask

    task automatic apply_b(input string req, input logic [11:0] c, input logic [23:0] cfg);
        logic [15:0] s, e;
        @(negedge clk);
        b_cl  = c;
        b_cfg = cfg;
        #1;
        model(NB, {4'd0, c}, {8'd0, cfg}, s, e);
        check({req, " sum"}, 32'(b_sum), 32'(s[NB-1:0]));
        check({req, " err"}, {19'd0, b_any, b_err}, {19'd0, (e != 0), e[NB-1:0]});
    endtask

    task automatic t_quiet();
        apply_a("R3 idle", '0, '0);
        apply_a("R3 idle codes", '0, 32'hFFFF_FFFF);
        apply_b("R3 idle small", '0, '0);
    endtask

    task automatic t_single_hot();
        for (int i = 0; i < NA; i++)
            for (int k = 0; k < 4; k++)
                apply_a("R1 R2 R4 single", 16'(1) << i, {16{2'(k)}});
    endtask

    task automatic t_edge_windows();
        logic [15:0] m0, mp, ml;
        m0 = '0; mp = '0; ml = '0;
        for (int i = 0; i < NA; i++)
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                a_cl  = 16'(1) << i;
                a_cfg = {16{2'(k)}};
                #1;
                if (a_sum[0])      m0[i] = 1'b1;
                if (a_sum[NA-2])   mp[i] = 1'b1;
                if (a_sum[NA-1])   ml[i] = 1'b1;
            end
        check("R5 macrocell 0 sources",    32'(m0), 32'h0007);
        check("R5 second-to-last sources", 32'(mp), 32'hE000);
        check("R5 last sources",           32'(ml), 32'hC000);
    endtask

    task automatic t_interior();
        for (int v = 0; v < 200; v++) begin
            @(negedge clk);
            a_cl  = 16'($urandom);
            a_cfg = $urandom;
            #1;
            check("R6 interior flags", 32'(a_err & 16'h7FFC), 32'd0);
        end
    endtask

    task automatic t_random();
        for (int v = 0; v < 3000; v++)
            apply_a("R2 R4 random", 16'($urandom), $urandom);
    endtask

    task automatic t_small();
        logic [11:0] m0, ml;
        for (int v = 0; v < 2000; v++)
            apply_b("R7 random", 12'($urandom), 24'($urandom));
        m0 = '0; ml = '0;
        for (int i = 0; i < NB; i++)
            for (int k = 0; k < 4; k++) begin
                apply_b("R7 single", 12'(1) << i, {12{2'(k)}});
                if (b_sum[0])    m0[i] = 1'b1;
                if (b_sum[NB-1]) ml[i] = 1'b1;
            end
        check("R7 small macrocell 0 sources", 32'(m0), 32'h007);
        check("R7 small last sources",        32'(ml), 32'hC00);
    endtask

    task automatic t_comb();
        @(negedge clk);
        a_cl  = 16'h0010;
        a_cfg = {16{2'd1}};
        #1;
        check("R8 follows", 32'(a_sum), 32'h0010);
        a_cl = 16'h0000;
        #1;
        check("R8 clears without clock", 32'(a_sum), 32'h0000);
        a_cfg = {16{2'd3}};
        a_cl  = 16'h0010;
        #1;
        check("R8 cfg change", 32'(a_sum), 32'h0004);
    endtask

    initial begin
        a_cl = '0; a_cfg = '0; b_cl = '0; b_cfg = '0;
        repeat (2) @(negedge clk);
        t_quiet();
        t_single_hot();
        t_edge_windows();
        t_interior();
        t_random();
        t_small();
        t_comb();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #1_500_000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule